// File: doc/BRIEF.md
# Masked Address-Range Handler Dispatcher

This block decides which handler subroutine, if any, serves a cartridge bus access. It holds four separate tables, one for each access class: program-space read, program-space write, character-space read and character-space write. A configuration command adds a binding to one of these tables. Each binding carries an inclusive start and end address, a match mask and an 8-bit subroutine number. The mask lists the address bits that must equal the same bits of the start address. The command also holds single bindings for the console-reset event and the disk-IRQ event.

On each bus access strobe, the block searches the table for the access class. It registers the result for one cycle: either the winning subroutine number, or a miss. On a miss, the access behaves as plain unbanked ROM. With the result it registers the two handler parameters. The first is the bus address. The second is the write data on write classes and zero on read classes. The block does not run the handler and does not drive bus data.

Each table has `SLOTS` entries that are filled in order. Once a table is full, a new binding overwrites the oldest one. When several bindings match, the most recently written one wins.

Top module: `hdm_dispatch`

## Requirements
- R1: After reset, all tables are empty, `hit_valid` and `hit_found` are 0, and both event bindings read unbound with subroutine 0.
- R2: A command with `cfg_op` equal to 0x10, 0x11, 0x12 or 0x13 adds a binding to the table for `acc_class` 0 (program read), 1 (program write), 2 (character read) or 3 (character write) respectively. Tables of other classes are unaffected.
- R3: A binding matches an address only when start <= address <= end, both bounds inclusive, and the address agrees with the start address on every bit set in the mask.
- R4: When no binding of the access class matches, `hit_found` is 0 and `hit_sub` is 0.
- R5: When several bindings of one class match, `hit_sub` is the subroutine of the binding written most recently.
- R6: Each class holds `SLOTS` bindings. When all are used, the next binding replaces the oldest one of that class.
- R7: The result appears exactly one clock after an `acc_strobe` cycle, with `hit_valid` high for that one cycle. Without a strobe, `hit_valid` is 0 and the other result outputs hold their values.
- R8: `hit_p0` carries the access address. `hit_p1` carries `acc_data` zero-extended on write classes (1 and 3) and 0 on read classes (0 and 2).
- R9: Opcode 0x18 binds the reset event and opcode 0x19 binds the disk-IRQ event to `cfg_sub`. The `*_bound` output goes to 1, and a later command of the same opcode replaces the subroutine.
- R10: A command with any other opcode changes no table and no event binding.
- R11: When a binding command and an access strobe fall in the same cycle, the access is judged against the tables as they stood before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration command present |
| cfg_op | input | 8 | Command opcode |
| cfg_sub | input | SUB_W | Subroutine number to bind |
| cfg_start | input | ADDR_W | Range start address (working register) |
| cfg_end | input | ADDR_W | Range end address (shadow working register) |
| cfg_mask | input | ADDR_W | Match mask (register 15) |
| acc_strobe | input | 1 | Bus access strobe |
| acc_class | input | 2 | Access class, encoded as in R2 |
| acc_addr | input | ADDR_W | Bus address |
| acc_data | input | DATA_W | Bus write data |
| hit_valid | output | 1 | Result valid, one cycle after a strobe |
| hit_found | output | 1 | A binding matched |
| hit_sub | output | SUB_W | Winning subroutine, 0 on a miss |
| hit_p0 | output | ADDR_W | First handler parameter (address) |
| hit_p1 | output | ADDR_W | Second handler parameter (write data) |
| rst_bound | output | 1 | Reset event bound |
| rst_sub | output | SUB_W | Reset event subroutine |
| dirq_bound | output | 1 | Disk-IRQ event bound |
| dirq_sub | output | SUB_W | Disk-IRQ event subroutine |

## Verification
A binding command and a lookup can occur in the same clock cycle. This matters most when the new binding covers the address being looked up. The bench drives a binding for a program-write range together with a program-write strobe inside that range, and expects a miss. It then expects a hit on the next strobe to the same address. The random phase also issues commands and strobes together. The bench model always resolves the access before it applies the command, so any lookup that sees the new binding too early shows up as a mismatch.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
   typedef enum logic [1:0] {
      CLS_PRG_RD = 2'd0,
      CLS_PRG_WR = 2'd1,
      CLS_CHR_RD = 2'd2,
      CLS_CHR_WR = 2'd3
   } acc_cls_e;

   localparam int          NUM_CLASS   = 4;
   localparam logic [5:0]  OP_BIND_HI  = 6'b000100;
   localparam logic [7:0]  OP_EVT_RST  = 8'h18;
   localparam logic [7:0]  OP_EVT_DIRQ = 8'h19;

   function automatic logic is_write_cls(input logic [1:0] c);
      return c[0];
   endfunction
endpackage

// File: rtl/hdm_slot_bank.sv
module hdm_slot_bank #(
   parameter int ADDR_W = 16,
   parameter int SUB_W  = 8,
   parameter int SLOTS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_start,
   input  logic [ADDR_W-1:0] wr_end,
   input  logic [ADDR_W-1:0] wr_mask,
   input  logic [SUB_W-1:0]  wr_sub,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [SUB_W-1:0]  lk_sub
);
   localparam int PTR_W = $clog2(SLOTS);

   logic [ADDR_W-1:0] st_q [SLOTS];
   logic [ADDR_W-1:0] en_q [SLOTS];
   logic [ADDR_W-1:0] mk_q [SLOTS];
   logic [SUB_W-1:0]  sb_q [SLOTS];
   logic [SLOTS-1:0]  vld_q;
   logic [PTR_W-1:0]  wptr_q;
   logic [SLOTS-1:0]  match;

   // occupancy and round-robin write pointer (oldest entry is next)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= '0;
         wptr_q <= '0;
      end else if (wr_en) begin
         vld_q[wptr_q] <= 1'b1;
         wptr_q        <= wptr_q + 1'b1;
      end
   end

   // payload storage, no reset needed: guarded by vld_q
   always_ff @(posedge clk) begin
      if (wr_en) begin
         st_q[wptr_q] <= wr_start;
         en_q[wptr_q] <= wr_end;
         mk_q[wptr_q] <= wr_mask;
         sb_q[wptr_q] <= wr_sub;
      end
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
      assign match[i] = vld_q[i]
                        && (lk_addr >= st_q[i])
                        && (lk_addr <= en_q[i])
                        && (((lk_addr ^ st_q[i]) & mk_q[i]) == '0);
   end

   // walk from oldest to newest; a later match overrides an earlier one
   always_comb begin
      lk_hit = 1'b0;
      lk_sub = '0;
      for (int k = 0; k < SLOTS; k++) begin
         logic [PTR_W-1:0] idx;
         idx = wptr_q + PTR_W'(k);
         if (match[idx]) begin
            lk_hit = 1'b1;
            lk_sub = sb_q[idx];
         end
      end
   end
endmodule

// File: rtl/hdm_event_bind.sv
module hdm_event_bind #(
   parameter int         SUB_W  = 8,
   parameter logic [7:0] OPCODE = 8'h18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic [7:0]       cfg_op,
   input  logic [SUB_W-1:0] cfg_sub,
   output logic             bound,
   output logic [SUB_W-1:0] sub
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bound <= 1'b0;
         sub   <= '0;
      end else if (cfg_valid && (cfg_op == OPCODE)) begin
         bound <= 1'b1;
         sub   <= cfg_sub;
      end
   end
endmodule

// File: rtl/hdm_dispatch.sv
module hdm_dispatch
   import hdm_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int SUB_W  = 8,
   parameter int SLOTS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [7:0]        cfg_op,
   input  logic [SUB_W-1:0]  cfg_sub,
   input  logic [ADDR_W-1:0] cfg_start,
   input  logic [ADDR_W-1:0] cfg_end,
   input  logic [ADDR_W-1:0] cfg_mask,
   input  logic              acc_strobe,
   input  logic [1:0]        acc_class,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_data,
   output logic              hit_valid,
   output logic              hit_found,
   output logic [SUB_W-1:0]  hit_sub,
   output logic [ADDR_W-1:0] hit_p0,
   output logic [ADDR_W-1:0] hit_p1,
   output logic              rst_bound,
   output logic [SUB_W-1:0]  rst_sub,
   output logic              dirq_bound,
   output logic [SUB_W-1:0]  dirq_sub
);
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("hdm_dispatch: SLOTS must be a power of two, at least 2");
   end
   if (ADDR_W < DATA_W) begin : g_bad_width
      $error("hdm_dispatch: ADDR_W must cover DATA_W");
   end

   logic             cls_hit [NUM_CLASS];
   logic [SUB_W-1:0] cls_sub [NUM_CLASS];
   logic             bind_cmd;

   assign bind_cmd = cfg_valid && (cfg_op[7:2] == OP_BIND_HI);

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
      hdm_slot_bank #(
         .ADDR_W(ADDR_W), .SUB_W(SUB_W), .SLOTS(SLOTS)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bind_cmd && (cfg_op[1:0] == 2'(c))),
         .wr_start(cfg_start),
         .wr_end  (cfg_end),
         .wr_mask (cfg_mask),
         .wr_sub  (cfg_sub),
         .lk_addr (acc_addr),
         .lk_hit  (cls_hit[c]),
         .lk_sub  (cls_sub[c])
      );
   end

   hdm_event_bind #(.SUB_W(SUB_W), .OPCODE(OP_EVT_RST)) u_evt_rst (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
      .cfg_sub(cfg_sub), .bound(rst_bound), .sub(rst_sub)
   );

   hdm_event_bind #(.SUB_W(SUB_W), .OPCODE(OP_EVT_DIRQ)) u_evt_dirq (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
      .cfg_sub(cfg_sub), .bound(dirq_bound), .sub(dirq_sub)
   );

   // result stage: captured once per strobe, held otherwise
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_valid <= 1'b0;
         hit_found <= 1'b0;
         hit_sub   <= '0;
         hit_p0    <= '0;
         hit_p1    <= '0;
      end else begin
         hit_valid <= acc_strobe;
         if (acc_strobe) begin
            hit_found <= cls_hit[acc_class];
            hit_sub   <= cls_hit[acc_class] ? cls_sub[acc_class] : '0;
            hit_p0    <= acc_addr;
            hit_p1    <= is_write_cls(acc_class) ? ADDR_W'(acc_data) : '0;
         end
      end
   end
endmodule

// File: rtl/hdm_dispatch_chk.sv
module hdm_dispatch_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int SUB_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_valid,
   input logic [7:0]        cfg_op,
   input logic [SUB_W-1:0]  cfg_sub,
   input logic              acc_strobe,
   input logic [1:0]        acc_class,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              hit_valid,
   input logic              hit_found,
   input logic [SUB_W-1:0]  hit_sub,
   input logic [ADDR_W-1:0] hit_p0,
   input logic [ADDR_W-1:0] hit_p1,
   input logic              rst_bound,
   input logic [SUB_W-1:0]  rst_sub,
   input logic              dirq_bound,
   input logic [SUB_W-1:0]  dirq_sub
);
   // R7
   strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_strobe |=> hit_valid);
   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_strobe |=> (!hit_valid && $stable(hit_sub) && $stable(hit_found)));
   // R8
   param_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_strobe |=> (hit_p0 == $past(acc_addr)));
   // R8
   read_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_strobe && !acc_class[0]) |=> (hit_p1 == '0));
   // R4
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !hit_found) |-> (hit_sub == '0));
   // R9
   reset_bind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_op == 8'h18) |=> (rst_bound && rst_sub == $past(cfg_sub)));
   // R9
   dirq_bind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_op == 8'h19) |=> (dirq_bound && dirq_sub == $past(cfg_sub)));
   // R10
   reset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_valid && cfg_op == 8'h18) |=> ($stable(rst_sub) && $stable(rst_bound)));
   // R10
   dirq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_valid && cfg_op == 8'h19) |=> ($stable(dirq_sub) && $stable(dirq_bound)));
endmodule

bind hdm_dispatch hdm_dispatch_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUB_W(SUB_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
   .cfg_sub(cfg_sub), .acc_strobe(acc_strobe), .acc_class(acc_class),
   .acc_addr(acc_addr), .hit_valid(hit_valid), .hit_found(hit_found),
   .hit_sub(hit_sub), .hit_p0(hit_p0), .hit_p1(hit_p1),
   .rst_bound(rst_bound), .rst_sub(rst_sub),
   .dirq_bound(dirq_bound), .dirq_sub(dirq_sub)
);

// File: tb/hdm_dispatch_test.sv
module hdm_dispatch_test;
   localparam int PERIOD = 10;
   localparam int SLOTS  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic [7:0]  cfg_op = '0;
   logic [7:0]  cfg_sub = '0;
   logic [15:0] cfg_start = '0, cfg_end = '0, cfg_mask = '0;
   logic        acc_strobe = 1'b0;
   logic [1:0]  acc_class = '0;
   logic [15:0] acc_addr = '0;
   logic [7:0]  acc_data = '0;
   logic        hit_valid, hit_found, rst_bound, dirq_bound;
   logic [7:0]  hit_sub, rst_sub, dirq_sub;
   logic [15:0] hit_p0, hit_p1;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // bench model
   int m_st [4][SLOTS], m_en [4][SLOTS], m_mk [4][SLOTS], m_sb [4][SLOTS], m_seq [4][SLOTS];
   bit m_vld [4][SLOTS];
   int m_ptr [4];
   int seq_ctr = 0;
   bit e_rb = 0, e_db = 0;
   int e_rs = 0, e_ds = 0;

   always #(PERIOD/2) clk = ~clk;

   hdm_dispatch #(.ADDR_W(16), .DATA_W(8), .SUB_W(8), .SLOTS(SLOTS)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
      .cfg_sub(cfg_sub), .cfg_start(cfg_start), .cfg_end(cfg_end),
      .cfg_mask(cfg_mask), .acc_strobe(acc_strobe), .acc_class(acc_class),
      .acc_addr(acc_addr), .acc_data(acc_data), .hit_valid(hit_valid),
      .hit_found(hit_found), .hit_sub(hit_sub), .hit_p0(hit_p0), .hit_p1(hit_p1),
      .rst_bound(rst_bound), .rst_sub(rst_sub),
      .dirq_bound(dirq_bound), .dirq_sub(dirq_sub)
   );

   task automatic chk(input string tag, input longint got, input longint exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // newest matching binding by write sequence number
   task automatic model_lookup(input int c, input int a, output bit f, output int s);
      int best = -1;
      f = 0; s = 0;
      for (int i = 0; i < SLOTS; i++) begin
         if (m_vld[c][i] && a >= m_st[c][i] && a <= m_en[c][i]
             && ((a ^ m_st[c][i]) & m_mk[c][i]) == 0 && m_seq[c][i] > best) begin
            best = m_seq[c][i]; f = 1; s = m_sb[c][i];
         end
      end
   endtask

   task automatic model_cfg(input int op, input int sub, input int st, input int en, input int mk);
      if (op >= 8'h10 && op <= 8'h13) begin
         int c = op & 3;
         int p = m_ptr[c];
         m_st[c][p] = st; m_en[c][p] = en; m_mk[c][p] = mk; m_sb[c][p] = sub;
         m_vld[c][p] = 1; m_seq[c][p] = seq_ctr++;
         m_ptr[c] = (p + 1) % SLOTS;
      end else if (op == 8'h18) begin
         e_rb = 1; e_rs = sub;
      end else if (op == 8'h19) begin
         e_db = 1; e_ds = sub;
      end
   endtask

   task automatic step(input string tag, input bit cv, input int op, input int sub,
                       input int st, input int en, input int mk,
                       input bit as, input int cls, input int addr, input int data);
      bit ef; int es;
      @(negedge clk);
      cfg_valid = cv; cfg_op = 8'(op); cfg_sub = 8'(sub);
      cfg_start = 16'(st); cfg_end = 16'(en); cfg_mask = 16'(mk);
      acc_strobe = as; acc_class = 2'(cls); acc_addr = 16'(addr); acc_data = 8'(data);
      model_lookup(cls, addr, ef, es);
      @(posedge clk);
      #1;
      if (as) begin
         chk({tag, " R7 valid"}, hit_valid, 1);
         chk({tag, " found"}, hit_found, ef);
         chk({tag, " sub"}, hit_sub, es);
         chk({tag, " R8 p0"}, hit_p0, addr);
         chk({tag, " R8 p1"}, hit_p1, (cls & 1) ? data : 0);
      end else begin
         chk({tag, " R7 idle"}, hit_valid, 0);
      end
      if (cv) model_cfg(op, sub, st, en, mk);
      chk({tag, " R9 events"}, {rst_bound, rst_sub, dirq_bound, dirq_sub},
          {e_rb, 8'(e_rs), e_db, 8'(e_ds)});
      cfg_valid = 0; acc_strobe = 0;
   endtask

   task automatic bind_r(input string tag, input int op, input int sub,
                         input int st, input int en, input int mk);
      step(tag, 1, op, sub, st, en, mk, 0, 0, 0, 0);
   endtask

   task automatic look(input string tag, input int cls, input int addr, input int data);
      step(tag, 0, 0, 0, 0, 0, 0, 1, cls, addr, data);
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED1);
      for (int c = 0; c < 4; c++) begin
         m_ptr[c] = 0;
         for (int i = 0; i < SLOTS; i++) m_vld[c][i] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 hit_valid", hit_valid, 0);
      chk("R1 hit_found", hit_found, 0);
      chk("R1 events", {rst_bound, rst_sub, dirq_bound, dirq_sub}, 0);
      @(negedge clk); rst_n = 1;
      look("R1 empty", 0, 16'h8000, 0);

      // R2 R3 inclusive range, class separation
      bind_r("R2 bind", 8'h10, 5, 16'h8000, 16'h8FFF, 0);
      look("R3 low edge", 0, 16'h8000, 0);
      look("R3 high edge", 0, 16'h8FFF, 0);
      look("R4 past end", 0, 16'h9000, 0);
      look("R2 other class", 1, 16'h8000, 8'h3C);
      chk("R2 other class miss", hit_found, 0);
      // R3 mask rule
      bind_r("R3 bind", 8'h12, 7, 16'h0000, 16'h1FFF, 16'h0400);
      look("R3 mask reject", 2, 16'h0400, 0);
      chk("R3 mask reject miss", hit_found, 0);
      look("R3 mask accept", 2, 16'h0800, 0);
      chk("R3 mask accept sub", hit_sub, 7);
      // R5 newest wins
      bind_r("R5 bind", 8'h10, 9, 16'h8000, 16'h80FF, 0);
      look("R5 overlap", 0, 16'h8010, 0);
      chk("R5 newest sub", hit_sub, 9);
      // R10 ignored opcodes
      bind_r("R10 op14", 8'h14, 8'h33, 16'h8000, 16'h80FF, 0);
      bind_r("R10 op1A", 8'h1A, 8'h44, 0, 16'hFFFF, 0);
      look("R10 after", 0, 16'h8010, 0);
      chk("R10 table untouched", hit_sub, 9);
      // R9 events
      bind_r("R9 reset", 8'h18, 8'h21, 0, 0, 0);
      bind_r("R9 dirq", 8'h19, 8'h42, 0, 0, 0);
      bind_r("R9 rebind", 8'h18, 8'h22, 0, 0, 0);
      chk("R9 rebind sub", rst_sub, 8'h22);
      // R11 same-cycle bind and access
      step("R11 same", 1, 8'h11, 8'h66, 16'h6000, 16'h7FFF, 0, 1, 1, 16'h6100, 8'hA5);
      chk("R11 old table miss", hit_found, 0);
      look("R11 next", 1, 16'h6100, 8'h5A);
      chk("R11 new table hit", hit_sub, 8'h66);
      // R7 hold
      step("R7 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R7 hold sub", hit_sub, 8'h66);
      // R6 overwrite oldest
      for (int i = 0; i <= SLOTS; i++)
         bind_r("R6 fill", 8'h13, i + 1, i * 256, i * 256 + 255, 0);
      look("R6 oldest gone", 3, 16'h0010, 8'h11);
      chk("R6 oldest miss", hit_found, 0);
      look("R6 kept", 3, 16'h0110, 8'h22);
      chk("R6 kept sub", hit_sub, 2);
      look("R6 newest", 3, 16'h0810, 8'h33);
      chk("R6 newest sub", hit_sub, 9);

      // random mix
      for (int n = 0; n < 600; n++) begin
         int r, op, st;
         r = int'($urandom_range(0, 9));
         op = (r < 6) ? 8'h10 + int'($urandom_range(0, 3)) :
              (r == 6) ? 8'h18 : (r == 7) ? 8'h19 : int'($urandom_range(0, 255));
         st = int'($urandom_range(0, 255));
         step("R3 R5 R6 R11 random", $urandom_range(0, 2) == 0, op,
              int'($urandom_range(0, 255)), st, st + int'($urandom_range(0, 64)),
              ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255)) : 0,
              $urandom_range(0, 3) != 0, int'($urandom_range(0, 3)),
              int'($urandom_range(0, 300)), int'($urandom_range(0, 255)));
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule